// File: doc/BRIEF.md
# Compare and Arithmetic Status Flag Unit

This unit holds the six condition flags of a 16-bit processor status word: unsigned greater-than, signed greater-than, equal, carry, overflow and odd parity. Each cycle in which an update is strobed, it takes an operation class, the two operands, the result word and the carry-out that the arithmetic datapath produced. It then rewrites the flags that this class affects. Flags the class does not touch keep their previous value.

The unit handles both word and byte operations. In byte mode, every operand and the result are taken from their low eight bits, and bit 7 serves as the sign bit. Shift and divide-check classes always work on full words. The datapath itself sits outside the unit and supplies the result and the carry-out as inputs.

The operation code selects one of eight classes. Each class has its own overflow rule: sign rules for add and subtract, a sign-drift rule for the arithmetic left shift, a most-negative-value rule for absolute value and negate, and a quotient-fit rule for the divide check.

Top module: `status_flag_unit`

## Requirements
- R1: After reset, all six flag outputs are 0.
- R2: In a cycle with `op_valid` low, no flag changes.
- R3: Compare (op_code 0): after the update, `lgt_o` is 1 if `src_a` is greater than `dst_b` as unsigned numbers, and `agt_o` is 1 if it is greater as two's-complement numbers. `eq_o` is 1 if the two are equal. Carry and overflow keep their values.
- R4: For add (1), subtract (2), shift left (3), shift right (4), abs/negate (5) and move/load (7), `lgt_o`, `agt_o` and `eq_o` compare `result` with zero: unsigned, signed and equality.
- R5: Add (1): `cy_o` takes `carry_in`. `ov_o` is 1 when the operand sign bits match and the result sign bit differs from the sign bit of `dst_b`.
- R6: Subtract (2): `cy_o` takes `carry_in`. `ov_o` is 1 when the operand sign bits differ and the result sign bit differs from the sign bit of `dst_b`.
- R7: Arithmetic shift left (3) with a nonzero `shift_cnt` n: `cy_o` takes `carry_in`. `ov_o` is 1 when any of the bits `dst_b[14]` down to `dst_b[15-n]` differs from `dst_b[15]`. With n = 0, carry and overflow keep their values.
- R8: Shift right (4): with a nonzero count, `cy_o` takes `carry_in`; with a zero count, carry keeps its value. Overflow keeps its value in both cases.
- R9: Abs/negate (5): `cy_o` takes `carry_in`. `ov_o` is 1 only when the source is the most negative value: 0x8000 in word mode, 0x80 in the low byte in byte mode.
- R10: Divide check (6): `ov_o` is 1 when `dst_b`, the upper dividend word, is greater than or equal to `src_a`, the divisor, as unsigned 16-bit values. All other flags keep their values.
- R11: `par_o` is updated only for byte operations of classes 0, 1, 2, 5 and 7. It is then the XOR of the low 8 bits of `result`, or of `src_a` for a compare. Otherwise it keeps its value.
- R12: In byte mode, classes 0, 1, 2, 5 and 7 use bits 7:0 with bit 7 as the sign bit. Classes 3, 4 and 6 ignore `byte_mode` and use the full word.
- R13: The `op_code` encoding is: 0 compare, 1 add, 2 subtract, 3 arithmetic shift left, 4 shift right (any kind), 5 abs/negate, 6 divide check, 7 move/load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Apply this cycle's operation to the flags |
| op_code | input | 3 | Operation class (R13) |
| byte_mode | input | 1 | Byte-sized operation |
| src_a | input | 16 | Source operand, or divisor for the divide check |
| dst_b | input | 16 | Destination operand, or upper dividend word |
| result | input | 16 | Result word from the datapath |
| carry_in | input | 1 | Carry-out, or last bit shifted out, from the datapath |
| shift_cnt | input | 4 | Shift count, 0 to 15 |
| lgt_o | output | 1 | Unsigned greater-than flag |
| agt_o | output | 1 | Signed greater-than flag |
| eq_o | output | 1 | Equal flag |
| cy_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Odd parity flag |

## Verification
Every flag is a plain register, so a wrong update enable or a wrong value shows up at the outputs one clock after the offending operation. A missed hold shows up the same way. A flag that should have been left alone but was rewritten will differ from the model from that cycle onward, until a later operation legitimately overwrites it, so the bench compares all six outputs on every clock. The byte-mode sign position, the zero-count shift case and the 0x8000 and equal-divisor boundaries are each driven directly as well as in the random stream.

// File: rtl/status_flag_unit.sv
module status_flag_unit #(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic          byte_mode,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  dst_b,
  input  logic [W-1:0]  result,
  input  logic          carry_in,
  input  logic [CW-1:0] shift_cnt,
  output logic          lgt_o,
  output logic          agt_o,
  output logic          eq_o,
  output logic          cy_o,
  output logic          ov_o,
  output logic          par_o
);
  localparam logic [2:0] OP_CMP = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_SLA = 3'd3,
                         OP_SRT = 3'd4, OP_ABS = 3'd5, OP_DIV = 3'd6, OP_MOV = 3'd7;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic word_only, bm, cnt_nz;
  assign word_only = (op_code == OP_SLA) || (op_code == OP_SRT) || (op_code == OP_DIV);
  assign bm        = byte_mode && !word_only;
  assign cnt_nz    = |shift_cnt;

  // operands narrowed: zero-extended for unsigned, sign-extended for signed views
  logic [W-1:0] a_u, b_u, r_u, a_s, r_s, b_s;
  assign a_u = bm ? {{(W-BW){1'b0}}, src_a[BW-1:0]} : src_a;
  assign b_u = bm ? {{(W-BW){1'b0}}, dst_b[BW-1:0]} : dst_b;
  assign r_u = bm ? {{(W-BW){1'b0}}, result[BW-1:0]} : result;
  assign a_s = bm ? {{(W-BW){src_a[BW-1]}}, src_a[BW-1:0]} : src_a;
  assign b_s = bm ? {{(W-BW){dst_b[BW-1]}}, dst_b[BW-1:0]} : dst_b;
  assign r_s = bm ? {{(W-BW){result[BW-1]}}, result[BW-1:0]} : result;

  logic a_m, b_m, r_m;
  assign a_m = a_s[W-1];
  assign b_m = b_s[W-1];
  assign r_m = r_s[W-1];

  logic is_cmp;
  logic [W-1:0] x_u, y_u, x_s, y_s;
  assign is_cmp = (op_code == OP_CMP);
  assign x_u = is_cmp ? a_u : r_u;
  assign y_u = is_cmp ? b_u : '0;
  assign x_s = is_cmp ? a_s : r_s;
  assign y_s = is_cmp ? b_s : '0;

  // arithmetic shift left: top n+1 bits of the operand must all match
  logic [W-1:0] sla_mask, sla_seg;
  assign sla_mask = ~(ALL1 >> ({1'b0, shift_cnt} + 5'd1));
  assign sla_seg  = dst_b & sla_mask;

  logic ov_val;
  always_comb begin
    case (op_code)
      OP_ADD:  ov_val = (a_m == b_m) && (r_m != b_m);
      OP_SUB:  ov_val = (a_m != b_m) && (r_m != b_m);
      OP_SLA:  ov_val = (sla_seg != '0) && (sla_seg != sla_mask);
      OP_ABS:  ov_val = bm ? (src_a[BW-1:0] == {1'b1, {(BW-1){1'b0}}})
                           : (src_a == {1'b1, {(W-1){1'b0}}});
      OP_DIV:  ov_val = dst_b >= src_a;
      default: ov_val = ov_o;
    endcase
  end

  logic upd_cmp, upd_cy, upd_ov, upd_par;
  assign upd_cmp = op_valid && (op_code != OP_DIV);
  assign upd_cy  = op_valid && ((op_code == OP_ADD) || (op_code == OP_SUB) || (op_code == OP_ABS) ||
                                (((op_code == OP_SLA) || (op_code == OP_SRT)) && cnt_nz));
  assign upd_ov  = op_valid && ((op_code == OP_ADD) || (op_code == OP_SUB) || (op_code == OP_ABS) ||
                                (op_code == OP_DIV) || ((op_code == OP_SLA) && cnt_nz));
  assign upd_par = op_valid && bm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lgt_o <= 1'b0; agt_o <= 1'b0; eq_o <= 1'b0;
      cy_o  <= 1'b0; ov_o  <= 1'b0; par_o <= 1'b0;
    end else begin
      if (upd_cmp) begin
        lgt_o <= x_u > y_u;
        agt_o <= $signed(x_s) > $signed(y_s);
        eq_o  <= x_u == y_u;
      end
      if (upd_cy)  cy_o  <= carry_in;
      if (upd_ov)  ov_o  <= ov_val;
      if (upd_par) par_o <= ^(is_cmp ? src_a[BW-1:0] : result[BW-1:0]);
    end
  end

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({lgt_o, agt_o, eq_o, cy_o, ov_o, par_o}));
  a_r3_cmp_keeps_cy_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> $stable({cy_o, ov_o}));
  a_r4_eq_excludes_gt: assert property (@(posedge clk) disable iff (!rst_n)
    eq_o |-> !(lgt_o || agt_o));
  a_r8_srt_keeps_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SRT) |=> $stable(ov_o));
  a_r9_abs_ov_only_minneg: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ABS && !byte_mode && src_a != 16'h8000) |=> !ov_o);
  a_r10_div_only_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DIV) |=> $stable({lgt_o, agt_o, eq_o, cy_o, par_o}));
  a_r11_word_keeps_par: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !byte_mode) |=> $stable(par_o));
  a_r7_sla_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SLA && shift_cnt == '0) |=> $stable({cy_o, ov_o}));
endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic byte_mode = 1'b0;
  logic [15:0] src_a = '0, dst_b = '0, result = '0;
  logic carry_in = 1'b0;
  logic [3:0] shift_cnt = '0;
  logic lgt_o, agt_o, eq_o, cy_o, ov_o, par_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_flag[6];   // 0 lgt 1 agt 2 eq 3 cy 4 ov 5 par

  always #5 clk = ~clk;

  status_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .byte_mode(byte_mode),
    .src_a(src_a), .dst_b(dst_b), .result(result), .carry_in(carry_in), .shift_cnt(shift_cnt),
    .lgt_o(lgt_o), .agt_o(agt_o), .eq_o(eq_o), .cy_o(cy_o), .ov_o(ov_o), .par_o(par_o)
  );

  function automatic string req_tag(int flag, bit v, int op, bit bm);
    if (!v) return "R2";
    if (flag == 5) return "R11";
    if (bm && (op == 3 || op == 4 || op == 6)) return "R12";
    case (op)
      0: return "R3";
      1: return (flag < 3) ? "R4" : "R5";
      2: return (flag < 3) ? "R4" : "R6";
      3: return (flag < 3) ? "R4" : "R7";
      4: return (flag < 3) ? "R4" : "R8";
      5: return (flag < 3) ? "R4" : "R9";
      6: return "R10";
      default: return "R4";   // move/load, code 7 per R13
    endcase
  endfunction

  // behavioural model of the next flag state (R3..R12)
  task automatic model_update();
    int op, m, mask, ua, ub, ur, sa, sb, sr, x, y, xs, ys;
    bit nb, ov;
    if (!op_valid) return;
    op = op_code;
    nb = byte_mode && !(op == 3 || op == 4 || op == 6);
    m = nb ? 7 : 15;
    mask = nb ? 'hFF : 'hFFFF;
    ua = src_a & mask; ub = dst_b & mask; ur = result & mask;
    sa = ((ua >> m) & 1) ? ua - (mask + 1) : ua;
    sb = ((ub >> m) & 1) ? ub - (mask + 1) : ub;
    sr = ((ur >> m) & 1) ? ur - (mask + 1) : ur;
    if (op != 6) begin
      if (op == 0) begin x = ua; y = ub; xs = sa; ys = sb; end
      else begin x = ur; y = 0; xs = sr; ys = 0; end
      m_flag[0] = (x > y); m_flag[1] = (xs > ys); m_flag[2] = (x == y);
    end
    case (op)
      1: begin m_flag[3] = carry_in; m_flag[4] = ((sa < 0) == (sb < 0)) && ((sr < 0) != (sb < 0)); end
      2: begin m_flag[3] = carry_in; m_flag[4] = ((sa < 0) != (sb < 0)) && ((sr < 0) != (sb < 0)); end
      3: if (shift_cnt != 0) begin
           m_flag[3] = carry_in;
           ov = 0;
           for (int i = 1; i <= shift_cnt; i++) if (dst_b[15 - i] != dst_b[15]) ov = 1;
           m_flag[4] = ov;
         end
      4: if (shift_cnt != 0) m_flag[3] = carry_in;
      5: begin m_flag[3] = carry_in; m_flag[4] = (ua == (mask + 1) / 2); end
      6: m_flag[4] = (dst_b >= src_a);
      default: ;
    endcase
    if (nb) begin
      x = (op == 0) ? ua : ur;
      ov = 0;
      for (int i = 0; i < 8; i++) ov ^= x[i];
      m_flag[5] = ov;
    end
  endtask

  task automatic check_all(string why);
    bit act[6];
    act = '{lgt_o, agt_o, eq_o, cy_o, ov_o, par_o};
    for (int f = 0; f < 6; f++) begin
      n_chk++;
      if (act[f] !== m_flag[f][0]) begin
        n_bad++;
        $display("FAIL %s flag%0d op=%0d bm=%0d a=%h b=%h r=%h cnt=%0d: actual %0b expected %0b",
                 why, f, op_code, byte_mode, src_a, dst_b, result, shift_cnt, act[f], m_flag[f][0]);
      end
    end
  endtask

  task automatic step(bit v, int op, bit bm, int a, int b, int r, bit c, int cnt);
    string t;
    op_valid = v; op_code = op[2:0]; byte_mode = bm;
    src_a = a[15:0]; dst_b = b[15:0]; result = r[15:0]; carry_in = c; shift_cnt = cnt[3:0];
    model_update();
    t = req_tag(3, v, op, bm);
    @(negedge clk);
    check_all(t);
  endtask

  initial begin
    for (int f = 0; f < 6; f++) m_flag[f] = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // directed corners
    step(1, 0, 0, 'h0005, 'hFFFF, 0, 1, 0);        // R3 unsigned less, signed greater
    step(1, 0, 0, 'h1234, 'h1234, 0, 0, 0);        // R3 equal
    step(1, 0, 1, 'h0080, 'h0001, 0, 0, 0);        // R12 byte sign at bit 7, R11 parity
    step(1, 1, 0, 'h7FFF, 'h0001, 'h8000, 0, 0);   // R5 overflow
    step(1, 2, 0, 'h0001, 'h8000, 'h7FFF, 1, 0);   // R6 overflow
    step(1, 1, 1, 'h0040, 'h0040, 'h0080, 0, 0);   // R5 byte overflow
    step(1, 3, 0, 0, 'h4000, 'h8000, 0, 1);        // R7 msb change
    step(1, 3, 0, 0, 'hC000, 'h8000, 1, 1);        // R7 no change
    step(1, 3, 0, 0, 'h4000, 'h0000, 1, 0);        // R7 zero count holds
    step(1, 4, 0, 0, 'h0003, 'h0001, 1, 0);        // R8 zero count holds carry
    step(1, 4, 0, 0, 'h0003, 'h0001, 1, 1);        // R8
    step(1, 5, 0, 'h8000, 0, 'h8000, 0, 0);        // R9 most negative
    step(1, 5, 1, 'h1280, 0, 'h0080, 0, 0);        // R9 byte most negative
    step(1, 5, 0, 'h8001, 0, 'h7FFF, 0, 0);        // R9
    step(1, 6, 0, 'h0010, 'h0010, 0, 1, 0);        // R10 equal -> overflow
    step(1, 6, 1, 'h0011, 'h0010, 0, 1, 0);        // R10/R12 byte ignored
    step(1, 7, 1, 0, 0, 'h0007, 0, 0);             // R4 move, R11 parity
    step(0, 1, 1, 'hFFFF, 'hFFFF, 0, 1, 0);        // R2 idle
    step(1, 7, 0, 0, 0, 'h0000, 0, 0);             // R4 zero result, R11 word holds
    for (int i = 0; i < 4000; i++)
      step(($urandom % 5) != 0, $urandom % 8, $urandom % 2, $urandom, $urandom,
           ($urandom % 4 == 0) ? 0 : $urandom, $urandom % 2,
           ($urandom % 4 == 0) ? 0 : $urandom % 16);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule